// File: doc/BRIEF.md
# LRU Stack Distance Profiler

This block watches a stream of block-address references, each marked as a read or a write, and builds the statistics needed to evaluate a whole family of LRU set-associative caches in a single pass. For every set it keeps a recency-ordered stack that is `DEPTH` entries deep. For each reference it finds how deep the block sits in its set's stack, records that depth in a histogram of distance counters, and then moves the block to the top. A hit at depth k is a hit for every cache of associativity k or more and a miss for every smaller one. Software therefore gets the hit count for associativity a by adding distance counters 1 through a.

Each stack entry also carries a dirty level. The dirty level is the smallest cache size in which the block is currently modified. With it, the block counts write-backs separately for each cache size from 1 to `DEPTH` ways, all during the same pass. References enter through a valid/ready port and are processed one at a time. The counters are read through a combinational select-and-read port.

Top module: `lru_stack_profiler`

## Requirements
- R1: `ref_ready` is high while the block is idle. In the cycle after a reference is accepted (`ref_valid && ref_ready` at a clock edge), `ref_ready` is low for exactly one cycle. When `ref_ready` rises again, all counters already include that reference.
- R2: The set index is the low `SET_W` bits of `ref_addr`, and the remaining bits form the tag. References to one set never change the stack depths seen in another set.
- R3: The total reference counter (read at `rd_sel` = `DEPTH`) increases by one for every accepted reference, whether it hits or misses.
- R4: A reference whose block sits at depth k of its set's stack (1 = most recently used) increases distance counter k (read at `rd_sel` = k-1). A miss increases no distance counter.
- R5: After every reference the referenced block is at depth 1 of its set. Blocks that were above it move down by one and blocks below it keep their depth. The depth of a block is one plus the number of distinct other blocks of the same set referenced since its last use.
- R6: A miss pushes the block on top, and the entry that was at depth `DEPTH` is discarded. A block followed by `DEPTH` distinct other blocks of its set misses on its next reference.
- R7: A write makes the block dirty for every cache size. A read miss loads it clean for every size. A read hit at depth k leaves it dirty only for sizes of at least max(old dirty level, k), because caches smaller than k reload it clean.
- R8: Write-back counter s (read at `rd_sel` = `DEPTH`+s, s = 1..`DEPTH`) increases when a reference misses or hits deeper than s, and the entry at depth s is dirty for size s.
- R9: While `rst_n` is low at a clock edge, every counter is cleared and every stack is emptied, so the first later reference to any block is a miss.
- R10: `rd_data` shows the selected counter in the same cycle, and any `rd_sel` above 2*`DEPTH` reads zero. Counters are 32 bits and saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous clear, active low |
| ref_valid | input | 1 | A reference is offered |
| ref_ready | output | 1 | The block can accept a reference |
| ref_addr | input | ADDR_W | Block address: set index in the low bits, tag above |
| ref_write | input | 1 | 1 = write reference, 0 = read |
| rd_sel | input | SEL_W | Counter select |
| rd_data | output | 32 | Selected counter value |

## Verification
The hardest situation to reach is a dirty level that differs between cache sizes. In that case one block must be written back by a larger cache but not by a smaller one. This requires a write, then enough other blocks of the same set to push the written block down, then a read hit at a depth that lowers its dirty range, and then more misses that evict it size by size. The stimulus table builds this sequence in one set with five blocks. It checks all four write-back counters after every step, so raising the dirty level too far or not far enough shows up as an early or missing write-back at a specific size.

// File: rtl/lru_prof_pkg.sv
package lru_prof_pkg;
  localparam int CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {ST_IDLE, ST_BUSY} prof_state_e;

  // Saturating increment shared by every counter.
  function automatic cnt_t sat_inc(cnt_t v);
    return (&v) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/lru_find.sv
module lru_find #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 10,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            vld,
  input  logic [TAG_W-1:0]            tag,
  output logic [DEPTH-1:0]            hit_vec,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tags[i] == tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
endmodule

// File: rtl/lru_stack_mem.sv
module lru_stack_mem #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int DEPTH = 4,
  parameter int TAG_W = 10,
  parameter int IDX_W = 2,
  parameter int DLW   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd,
  input  logic [SET_W-1:0]            set_idx,
  input  logic [TAG_W-1:0]            tag,
  input  logic                        wr,
  input  logic                        hit,
  input  logic [IDX_W-1:0]            hit_idx,
  output logic [DEPTH-1:0][TAG_W-1:0] rd_tags,
  output logic [DEPTH-1:0]            rd_vld,
  output logic [DEPTH-1:0][DLW-1:0]   rd_dl,
  output logic [DEPTH-1:0]            wb_evt
);
  localparam logic [DLW-1:0] DL_CLEAN = DLW'(DEPTH + 1);

  logic [TAG_W-1:0] tag_q [SETS][DEPTH];
  logic             vld_q [SETS][DEPTH];
  logic [DLW-1:0]   dl_q  [SETS][DEPTH];

  logic [TAG_W-1:0] nxt_tag [DEPTH];
  logic             nxt_vld [DEPTH];
  logic [DLW-1:0]   nxt_dl  [DEPTH];
  logic [DLW-1:0]   ref_dl;

  // Dirty level after a read hit at depth k: smaller caches reloaded it clean.
  function automatic logic [DLW-1:0] dl_after_read(logic [DLW-1:0] old_dl, logic [IDX_W-1:0] idx);
    logic [DLW-1:0] k;
    k = DLW'(idx) + 1'b1;
    return (old_dl > k) ? old_dl : k;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rd_tags[i] = tag_q[set_idx][i];
      rd_vld[i]  = vld_q[set_idx][i];
      rd_dl[i]   = dl_q[set_idx][i];
    end
  end

  // Size i+1 evicts the entry at depth i+1 when the reference lies deeper.
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      wb_evt[i] = (!hit || (hit_idx > IDX_W'(i))) && rd_vld[i] && (rd_dl[i] <= DLW'(i + 1));
  end

  always_comb begin
    if (wr)       ref_dl = DLW'(1);
    else if (hit) ref_dl = dl_after_read(rd_dl[hit_idx], hit_idx);
    else          ref_dl = DL_CLEAN;
    nxt_tag[0] = tag;
    nxt_vld[0] = 1'b1;
    nxt_dl[0]  = ref_dl;
    for (int i = 1; i < DEPTH; i++) begin
      if (!hit || (IDX_W'(i) <= hit_idx)) begin
        nxt_tag[i] = rd_tags[i-1];
        nxt_vld[i] = rd_vld[i-1];
        nxt_dl[i]  = rd_dl[i-1];
      end else begin
        nxt_tag[i] = rd_tags[i];
        nxt_vld[i] = rd_vld[i];
        nxt_dl[i]  = rd_dl[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!rst_n) begin
          tag_q[s][i] <= '0;
          vld_q[s][i] <= 1'b0;
          dl_q[s][i]  <= DL_CLEAN;
        end else if (upd && (set_idx == SET_W'(s))) begin
          tag_q[s][i] <= nxt_tag[i];
          vld_q[s][i] <= nxt_vld[i];
          dl_q[s][i]  <= nxt_dl[i];
        end
      end
    end
  end

  a_r5_ref_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (rd_vld[0] && (rd_tags[0] == $past(tag))));

  a_r7_write_dirty_all: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wr) |=> (rd_dl[0] == DLW'(1)));

  a_r7_read_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr && !hit) |=> (rd_dl[0] == DL_CLEAN));
endmodule

// File: rtl/lru_counters.sv
module lru_counters
  import lru_prof_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [DEPTH-1:0] wb_evt,
  input  logic [SEL_W-1:0] rd_sel,
  output cnt_t             rd_data
);
  cnt_t dist_q [DEPTH];
  cnt_t wb_q   [DEPTH];
  cnt_t tot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dist_q[i] <= '0;
        wb_q[i]   <= '0;
      end
    end else if (upd) begin
      tot_q <= sat_inc(tot_q);
      for (int i = 0; i < DEPTH; i++) begin
        if (hit && (hit_idx == IDX_W'(i))) dist_q[i] <= sat_inc(dist_q[i]);
        if (wb_evt[i])                    wb_q[i]   <= sat_inc(wb_q[i]);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_W'(DEPTH)) rd_data = tot_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_sel == SEL_W'(i))             rd_data = dist_q[i];
      if (rd_sel == SEL_W'(DEPTH + 1 + i)) rd_data = wb_q[i];
    end
  end

  a_r3_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (tot_q != '1)) |=> (tot_q == $past(tot_q) + 1'b1));

  a_r4_dist_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hit && (dist_q[hit_idx] != '1)) |=> (dist_q[$past(hit_idx)] == $past(dist_q[hit_idx]) + 1'b1));

  a_r3_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(tot_q));
endmodule

// File: rtl/lru_stack_profiler.sv
module lru_stack_profiler
  import lru_prof_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 2,
  parameter int DEPTH  = 4,
  localparam int SEL_W = $clog2(2 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ref_write,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int DLW   = $clog2(DEPTH + 2);

  prof_state_e       state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_wr_q;
  logic              accept;
  logic              upd;

  logic [SET_W-1:0]            req_set;
  logic [TAG_W-1:0]            req_tag;
  logic [DEPTH-1:0][TAG_W-1:0] set_tags;
  logic [DEPTH-1:0]            set_vld;
  logic [DEPTH-1:0][DLW-1:0]   set_dl;
  logic [DEPTH-1:0]            hit_vec;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;
  logic [DEPTH-1:0]            wb_evt;

  assign ref_ready = (state_q == ST_IDLE);
  assign accept    = ref_valid && ref_ready;
  assign upd       = (state_q == ST_BUSY);
  assign req_set   = req_addr_q[SET_W-1:0];
  assign req_tag   = req_addr_q[ADDR_W-1:SET_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      req_addr_q <= '0;
      req_wr_q   <= 1'b0;
    end else if (accept) begin
      state_q    <= ST_BUSY;
      req_addr_q <= ref_addr;
      req_wr_q   <= ref_write;
    end else if (upd) begin
      state_q <= ST_IDLE;
    end
  end

  lru_stack_mem #(
    .SETS(SETS), .SET_W(SET_W), .DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .DLW(DLW)
  ) u_stack (
    .clk(clk), .rst_n(rst_n), .upd(upd), .set_idx(req_set), .tag(req_tag),
    .wr(req_wr_q), .hit(hit), .hit_idx(hit_idx),
    .rd_tags(set_tags), .rd_vld(set_vld), .rd_dl(set_dl), .wb_evt(wb_evt)
  );

  lru_find #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_find (
    .tags(set_tags), .vld(set_vld), .tag(req_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
  );

  lru_counters #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .upd(upd), .hit(hit), .hit_idx(hit_idx),
    .wb_evt(wb_evt), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ref_ready);

  a_r1_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ready |=> ref_ready);

  a_r5_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $onehot0(hit_vec));

  a_r8_no_wb_on_top_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hit && (hit_idx == '0)) |-> (wb_evt == '0));
endmodule

// File: tb/tb_lru_stack_profiler.sv
module tb_lru_stack_profiler;
  localparam int DEPTH = 4;
  localparam int SEL_W = 4;
  localparam int ROWS  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [11:0] ref_addr = '0;
  logic        ref_write = 1'b0;
  logic [SEL_W-1:0] rd_sel = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_dist [DEPTH];
  int exp_tot;

  always #2.5 clk = ~clk;

  lru_stack_profiler dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_addr(ref_addr), .ref_write(ref_write), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // Row: {clear, addr[11:0], write, depth (0 = miss), wb1, wb2, wb3, wb4 cumulative}
  localparam logic [48:0] TBL [ROWS] = '{
    {1'b0, 12'h010, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h020, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h010, 1'b0, 3'd2, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h011, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h010, 1'b0, 3'd1, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h030, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h040, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h020, 1'b0, 3'd4, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h050, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h010, 1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h040, 1'b0, 3'd4, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h011, 1'b0, 3'd1, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b1, 12'h102, 1'b1, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h202, 1'b0, 3'd0, 8'd1, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h102, 1'b0, 3'd2, 8'd1, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h302, 1'b0, 3'd0, 8'd1, 8'd0, 8'd0, 8'd0},
    {1'b0, 12'h402, 1'b0, 3'd0, 8'd1, 8'd1, 8'd0, 8'd0},
    {1'b0, 12'h502, 1'b0, 3'd0, 8'd1, 8'd1, 8'd1, 8'd0},
    {1'b0, 12'h202, 1'b1, 3'd0, 8'd1, 8'd1, 8'd1, 8'd1},
    {1'b0, 12'h302, 1'b0, 3'd4, 8'd2, 8'd1, 8'd1, 8'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int sel, output logic [31:0] v);
    rd_sel = SEL_W'(sel);
    #0.5;
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) exp_dist[i] = 0;
    exp_tot = 0;
  endtask

  // Offers one reference, checks the one-cycle busy window (R1).
  task automatic send(input logic [11:0] a, input logic w);
    @(negedge clk);
    check("R1 ready when idle", 32'(ref_ready), 32'd1);
    ref_valid = 1'b1;
    ref_addr  = a;
    ref_write = w;
    @(negedge clk);
    ref_valid = 1'b0;
    check("R1 busy after accept", 32'(ref_ready), 32'd0);
    @(negedge clk);
    check("R1 ready again", 32'(ref_ready), 32'd1);
  endtask

  task automatic check_hist(input string tag);
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, v);
      check({tag, " R4 distance counter"}, v, 32'(exp_dist[i]));
    end
    rd(DEPTH, v);
    check({tag, " R3 total"}, v, 32'(exp_tot));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R9 / R10: reset state of every readout and of the port
    for (int s = 0; s < 16; s++) begin
      rd(s, v);
      check("R9 counter clear after reset", v, 32'd0);
    end
    check("R1 ready after reset", 32'(ref_ready), 32'd1);

    // Table walk: R2 R4 R5 R6 on sets 0 and 1, then R7 R8 on set 2
    for (int r = 0; r < ROWS; r++) begin
      logic [48:0] e;
      int dep;
      e = TBL[r];
      if (e[48]) do_reset();
      send(e[47:36], e[35]);
      dep = int'(e[34:32]);
      exp_tot++;
      if (dep != 0) exp_dist[dep-1]++;
      check_hist($sformatf("row %0d R2 R5 R6", r));
      for (int s = 0; s < DEPTH; s++) begin
        rd(DEPTH + 1 + s, v);
        check($sformatf("row %0d R7 R8 write-back size %0d", r, s + 1), v, 32'(e[31-8*s -: 8]));
      end
    end

    // R10: selects above the mapped range read zero while counters are non-zero
    for (int s = 2 * DEPTH + 1; s < 16; s++) begin
      rd(s, v);
      check("R10 unmapped select", v, 32'd0);
    end

    // R9: clear empties the stacks; a block seen before misses again
    do_reset();
    send(12'h302, 1'b0);
    exp_tot = 1;
    check_hist("R9 stack emptied");
    send(12'h302, 1'b0);
    exp_tot = 2;
    exp_dist[0] = 1;
    check_hist("R9 top hit after refill");

    // R6: exactly DEPTH distinct blocks in between forces a miss, DEPTH-1 does not
    do_reset();
    send(12'h013, 1'b0);
    for (int i = 1; i < DEPTH; i++) send(12'(12'h013 + 16 * i), 1'b0);
    send(12'h013, 1'b0);
    exp_tot = DEPTH + 1;
    exp_dist[DEPTH-1] = 1;
    check_hist("R6 deepest hit");
    for (int i = 1; i <= DEPTH; i++) send(12'(12'h813 + 16 * i), 1'b0);
    send(12'h013, 1'b0);
    exp_tot = 2 * DEPTH + 2;
    check_hist("R6 pushed out");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule